// File: doc/BRIEF.md
# Dual-Clock Fine Timestamp Unit

This block produces event timestamps with fast-clock resolution while only a slow tick is kept running at all times. A wide slow counter advances on every slow tick. A short phase counter counts fast-clock cycles inside the current slow interval and is cleared at each slow tick. On every slow tick the unit records how many fast cycles the interval just ended contained. That measured count serves as the ratio of fast ticks per slow tick, because the ratio of the two clocks is generally not an integer.

The whole block runs on the fast clock. The slow clock's rising edge arrives as a synchronized one-cycle pulse. When an event strobe arrives, such as a radio start-of-frame interrupt, the slow count and the phase are frozen together. The next stage forms `slow * ratio + phase`, and the result is presented with a one-cycle valid pulse. If the fast count cannot be trusted, because the fast domain is off or no interval has been measured since it came back on, the unit reports a coarse timestamp instead.

Top module: `vht_timestamper`

## Requirements
- R1: The slow count increments by one at every clock edge where `slow_tick` is high, whether `fast_en` is high or low, and wraps modulo 2^SLOW_W (default 32 bits).
- R2: `wrap_pulse` is high for exactly one cycle, namely the cycle in which `slow_count` first reads 0 after wrapping from all ones.
- R3: The phase count becomes 0 at each `slow_tick` edge. At other edges it increments while `fast_en` is high. It holds while `fast_en` is low, and it saturates at all ones.
- R4: At a `slow_tick` edge that ends an interval during which `fast_en` stayed high throughout (the tick cycle included) and the phase did not saturate, `interval_ticks` becomes the phase count plus one. This equals the number of clock edges from the previous tick to this one.
- R5: An event strobe sampled at edge E latches the slow count and the phase together. At edge E+1, `ts_valid` or `ts_coarse` rises for one cycle, and `ts_value` then holds its value until the next event result.
- R6: For a fine result, `ts_value = slow * interval_ticks + phase` modulo 2^(SLOW_W+PH_W).
- R7: An event in the same cycle as a slow tick takes the incremented slow count, phase 0, and the interval count captured at that same edge.
- R8: If `fast_en` is low at the event, or no interval has been captured since reset or since `fast_en` last went low, `ts_coarse` pulses instead of `ts_valid`, and `ts_value` is the latched slow count zero-extended.
- R9: A tick ending an interval that was disabled at any point, or one in which the phase saturated, leaves `interval_ticks` unchanged and marks the ratio as lost, so that events before the next capture are coarse (R8).
- R10: After reset, `slow_count`, `interval_ticks` and `ts_value` read 0, and `ts_valid`, `ts_coarse` and `wrap_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; all logic is on this clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fast_en | input | 1 | High while the fast domain is counting |
| slow_tick | input | 1 | Synchronized one-cycle pulse per slow-clock rising edge |
| evt_stb | input | 1 | Event strobe requesting a timestamp |
| slow_count | output | SLOW_W | Current slow tick count |
| wrap_pulse | output | 1 | One-cycle pulse when the slow count wraps to 0 |
| interval_ticks | output | PH_W | Fast cycles in the last fully observed slow interval |
| ts_value | output | SLOW_W+PH_W | Most recent timestamp |
| ts_valid | output | 1 | One-cycle pulse: fine timestamp ready |
| ts_coarse | output | 1 | One-cycle pulse: coarse-only timestamp ready |

## Verification
`slow_count`, `wrap_pulse` and `interval_ticks` change at the edge that samples `slow_tick`, so the bench reads them at the following falling edge. A timestamp is due two edges after the strobe is driven: the first edge latches it and the second forms the result. The bench therefore reads `ts_valid`, `ts_coarse` and `ts_value` at the second falling edge after raising `evt_stb`, and checks at the next falling edge that the pulse has dropped. Every stimulus is driven at a falling edge. The bench counts the edges between ticks itself and computes the expected interval and phase from that count.

// File: rtl/vht_pkg.sv
package vht_pkg;

  // Kind of result pending from the event latch to the combiner
  typedef enum logic [1:0] {
    RES_NONE   = 2'd0,
    RES_FINE   = 2'd1,
    RES_COARSE = 2'd2
  } res_kind_e;

endpackage

// File: rtl/vht_rst_sync.sv
module vht_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];

endmodule

// File: rtl/vht_slow_counter.sv
module vht_slow_counter #(
  parameter int SLOW_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  output logic [SLOW_W-1:0] count_o,
  output logic              wrap_o
);

  localparam logic [SLOW_W-1:0] ALL_ONES = '1;

  logic [SLOW_W-1:0] count_q, count_d;
  logic              wrap_q,  wrap_d;

  always_comb begin
    count_d = count_q;
    wrap_d  = 1'b0;
    if (tick_i) begin
      count_d = count_q + SLOW_W'(1);
      wrap_d  = (count_q == ALL_ONES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      wrap_q  <= 1'b0;
    end else begin
      count_q <= count_d;
      wrap_q  <= wrap_d;
    end
  end

  assign count_o = count_q;
  assign wrap_o  = wrap_q;

  p_slow_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (count_q == $past(count_q) + SLOW_W'(1)));

  p_slow_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(count_q));

  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |-> (count_q == '0));

  p_wrap_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |=> !wrap_q || (count_q == '0 && $past(count_q) == ALL_ONES));

endmodule

// File: rtl/vht_phase_counter.sv
module vht_phase_counter #(
  parameter int PH_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            tick_i,
  output logic [PH_W-1:0] phase_o,
  output logic [PH_W-1:0] ratio_o,
  output logic [PH_W-1:0] ratio_nxt_o,
  output logic            ratio_ok_nxt_o
);

  localparam logic [PH_W-1:0] PH_MAX = '1;

  logic [PH_W-1:0] phase_q, phase_d;
  logic [PH_W-1:0] ratio_q, ratio_d;
  logic            clean_q, clean_d;
  logic            ok_q,    ok_d;
  logic            capture;
  logic            phase_ce;

  // Interval usable only if enabled throughout and not saturated
  assign capture  = tick_i && en_i && clean_q && (phase_q != PH_MAX);
  assign phase_ce = tick_i || (en_i && (phase_q != PH_MAX));

  always_comb begin
    phase_d = phase_q;
    if (phase_ce) begin
      if (tick_i) phase_d = '0;
      else        phase_d = phase_q + PH_W'(1);
    end
  end

  always_comb begin
    if (tick_i) clean_d = en_i;
    else        clean_d = clean_q && en_i;
  end

  always_comb begin
    ratio_d = ratio_q;
    ok_d    = ok_q;
    if (capture) begin
      ratio_d = phase_q + PH_W'(1);
      ok_d    = 1'b1;
    end else if (tick_i || !en_i) begin
      ok_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      ratio_q <= '0;
      clean_q <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      ratio_q <= ratio_d;
      clean_q <= clean_d;
      ok_q    <= ok_d;
    end
  end

  assign phase_o        = phase_q;
  assign ratio_o        = ratio_q;
  assign ratio_nxt_o    = ratio_d;
  assign ratio_ok_nxt_o = ok_d;

  p_phase_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (phase_q == '0));

  p_phase_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !en_i) |=> $stable(phase_q));

  p_phase_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && phase_q == PH_MAX) |=> (phase_q == PH_MAX));

  p_ratio_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !clean_q) |=> ($stable(ratio_q) && !ok_q));

endmodule

// File: rtl/vht_event_latch.sv
module vht_event_latch
  import vht_pkg::*;
#(
  parameter int SLOW_W = 32,
  parameter int PH_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_i,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [SLOW_W-1:0] slow_i,
  input  logic [PH_W-1:0]   phase_i,
  input  logic [PH_W-1:0]   ratio_nxt_i,
  input  logic              ratio_ok_nxt_i,
  output logic [SLOW_W-1:0] slow_o,
  output logic [PH_W-1:0]   phase_o,
  output logic [PH_W-1:0]   ratio_o,
  output res_kind_e         kind_o
);

  logic [SLOW_W-1:0] slow_q,  slow_d;
  logic [PH_W-1:0]   phase_q, phase_d;
  logic [PH_W-1:0]   ratio_q, ratio_d;
  res_kind_e         kind_q,  kind_d;
  logic              fine;

  assign fine = en_i && ratio_ok_nxt_i;

  always_comb begin
    slow_d  = slow_q;
    phase_d = phase_q;
    ratio_d = ratio_q;
    kind_d  = RES_NONE;
    if (evt_i) begin
      // A coincident tick resolves to phase 0 of the new interval
      slow_d  = tick_i ? slow_i + SLOW_W'(1) : slow_i;
      phase_d = tick_i ? '0 : phase_i;
      ratio_d = ratio_nxt_i;
      kind_d  = fine ? RES_FINE : RES_COARSE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q  <= '0;
      phase_q <= '0;
      ratio_q <= '0;
      kind_q  <= RES_NONE;
    end else begin
      slow_q  <= slow_d;
      phase_q <= phase_d;
      ratio_q <= ratio_d;
      kind_q  <= kind_d;
    end
  end

  assign slow_o  = slow_q;
  assign phase_o = phase_q;
  assign ratio_o = ratio_q;
  assign kind_o  = kind_q;

  p_coincident_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && tick_i) |=> (phase_q == '0));

  p_coarse_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !en_i) |=> (kind_q == RES_COARSE));

endmodule

// File: rtl/vht_combiner.sv
module vht_combiner
  import vht_pkg::*;
#(
  parameter int SLOW_W = 32,
  parameter int PH_W   = 16,
  localparam int TS_W  = SLOW_W + PH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  res_kind_e         kind_i,
  input  logic [SLOW_W-1:0] slow_i,
  input  logic [PH_W-1:0]   phase_i,
  input  logic [PH_W-1:0]   ratio_i,
  output logic [TS_W-1:0]   ts_o,
  output logic              valid_o,
  output logic              coarse_o
);

  logic [TS_W-1:0] ts_q, ts_d;
  logic [TS_W-1:0] scaled;
  logic            valid_q, valid_d;
  logic            coarse_q, coarse_d;
  logic            ts_ce;

  assign scaled = TS_W'(slow_i) * TS_W'(ratio_i);
  assign ts_ce  = (kind_i != RES_NONE);

  always_comb begin
    ts_d     = ts_q;
    valid_d  = 1'b0;
    coarse_d = 1'b0;
    if (ts_ce) begin
      if (kind_i == RES_FINE) begin
        ts_d    = scaled + TS_W'(phase_i);
        valid_d = 1'b1;
      end else begin
        ts_d     = TS_W'(slow_i);
        coarse_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q     <= '0;
      valid_q  <= 1'b0;
      coarse_q <= 1'b0;
    end else begin
      ts_q     <= ts_d;
      valid_q  <= valid_d;
      coarse_q <= coarse_d;
    end
  end

  assign ts_o     = ts_q;
  assign valid_o  = valid_q;
  assign coarse_o = coarse_q;

  always_comb begin
    if (rst_n) begin
      a_excl_r8: assert (!(valid_q && coarse_q));
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == RES_NONE) |=> $stable(ts_q));

endmodule

// File: rtl/vht_timestamper.sv
module vht_timestamper
  import vht_pkg::*;
#(
  parameter int SLOW_W = 32,
  parameter int PH_W   = 16,
  localparam int TS_W  = SLOW_W + PH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_en,
  input  logic              slow_tick,
  input  logic              evt_stb,
  output logic [SLOW_W-1:0] slow_count,
  output logic              wrap_pulse,
  output logic [PH_W-1:0]   interval_ticks,
  output logic [TS_W-1:0]   ts_value,
  output logic              ts_valid,
  output logic              ts_coarse
);

  logic              rst_n_s;
  logic [PH_W-1:0]   phase;
  logic [PH_W-1:0]   ratio_nxt;
  logic              ratio_ok_nxt;
  logic [SLOW_W-1:0] cap_slow;
  logic [PH_W-1:0]   cap_phase;
  logic [PH_W-1:0]   cap_ratio;
  res_kind_e         cap_kind;

  vht_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  vht_slow_counter #(.SLOW_W(SLOW_W)) u_slow (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .tick_i  (slow_tick),
    .count_o (slow_count),
    .wrap_o  (wrap_pulse)
  );

  vht_phase_counter #(.PH_W(PH_W)) u_phase (
    .clk            (clk),
    .rst_n          (rst_n_s),
    .en_i           (fast_en),
    .tick_i         (slow_tick),
    .phase_o        (phase),
    .ratio_o        (interval_ticks),
    .ratio_nxt_o    (ratio_nxt),
    .ratio_ok_nxt_o (ratio_ok_nxt)
  );

  vht_event_latch #(.SLOW_W(SLOW_W), .PH_W(PH_W)) u_latch (
    .clk            (clk),
    .rst_n          (rst_n_s),
    .evt_i          (evt_stb),
    .en_i           (fast_en),
    .tick_i         (slow_tick),
    .slow_i         (slow_count),
    .phase_i        (phase),
    .ratio_nxt_i    (ratio_nxt),
    .ratio_ok_nxt_i (ratio_ok_nxt),
    .slow_o         (cap_slow),
    .phase_o        (cap_phase),
    .ratio_o        (cap_ratio),
    .kind_o         (cap_kind)
  );

  vht_combiner #(.SLOW_W(SLOW_W), .PH_W(PH_W)) u_comb (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .kind_i   (cap_kind),
    .slow_i   (cap_slow),
    .phase_i  (cap_phase),
    .ratio_i  (cap_ratio),
    .ts_o     (ts_value),
    .valid_o  (ts_valid),
    .coarse_o (ts_coarse)
  );

  p_result_cause_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ts_valid || ts_coarse) |-> $past(evt_stb, 2));

  p_result_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ts_valid && !$past(evt_stb)) |=> !ts_valid);

endmodule

// File: tb/vht_timestamper_tb_top.sv
module vht_timestamper_tb_top;

  localparam int SW = 8;
  localparam int PW = 8;
  localparam int TW = SW + PW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fast_en = 1'b0;
  logic          slow_tick = 1'b0;
  logic          evt_stb = 1'b0;
  logic [SW-1:0] slow_count;
  logic          wrap_pulse;
  logic [PW-1:0] interval_ticks;
  logic [TW-1:0] ts_value;
  logic          ts_valid;
  logic          ts_coarse;

  int checks = 0;
  int fails  = 0;
  int exp_slow = 0;

  always #4 clk = ~clk;

  vht_timestamper #(.SLOW_W(SW), .PH_W(PW)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .fast_en        (fast_en),
    .slow_tick      (slow_tick),
    .evt_stb        (evt_stb),
    .slow_count     (slow_count),
    .wrap_pulse     (wrap_pulse),
    .interval_ticks (interval_ticks),
    .ts_value       (ts_value),
    .ts_valid       (ts_valid),
    .ts_coarse      (ts_coarse)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    slow_tick = 1'b1;
    @(negedge clk);
    slow_tick = 1'b0;
    exp_slow = (exp_slow + 1) % 256;
  endtask

  // Drives the strobe; returns at the negedge where the result is due
  task automatic fire_event(input logic with_tick);
    evt_stb = 1'b1;
    slow_tick = with_tick;
    @(negedge clk);
    evt_stb = 1'b0;
    slow_tick = 1'b0;
    if (with_tick) exp_slow = (exp_slow + 1) % 256;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10", "slow_count", int'(slow_count), 0);
    chk("R10", "interval_ticks", int'(interval_ticks), 0);
    chk("R10", "ts_value", int'(ts_value), 0);
    chk("R10", "flags", int'({ts_valid, ts_coarse, wrap_pulse}), 0);
  endtask

  task automatic t_wrap();
    fast_en = 1'b0;
    for (int i = 0; i < 255; i++) pulse_tick();
    chk("R1", "slow_count before wrap (fast off)", int'(slow_count), 255);
    chk("R2", "wrap before wrap", int'(wrap_pulse), 0);
    pulse_tick();
    chk("R1", "slow_count wrapped", int'(slow_count), 0);
    chk("R2", "wrap pulse", int'(wrap_pulse), 1);
    idle(1);
    chk("R2", "wrap pulse width", int'(wrap_pulse), 0);
  endtask

  task automatic t_sync();
    fast_en = 1'b1;
    pulse_tick();
    idle(9);
    pulse_tick();
    chk("R4", "interval 10", int'(interval_ticks), 10);
    idle(4);
    fire_event(1'b0);
    chk("R5", "valid pulse", int'(ts_valid), 1);
    chk("R6", "fine ts phase 4", int'(ts_value), exp_slow * 10 + 4);
    idle(1);
    chk("R5", "valid drops", int'(ts_valid), 0);
    chk("R5", "ts holds", int'(ts_value), exp_slow * 10 + 4);
  endtask

  task automatic t_coincident();
    pulse_tick();
    idle(6);
    fire_event(1'b1);
    chk("R7", "interval 7", int'(interval_ticks), 7);
    chk("R7", "valid", int'(ts_valid), 1);
    chk("R7", "ts new interval phase 0", int'(ts_value), exp_slow * 7);
  endtask

  task automatic t_ratio2();
    pulse_tick();
    idle(19);
    pulse_tick();
    chk("R4", "interval 20", int'(interval_ticks), 20);
    fire_event(1'b0);
    chk("R3", "phase 0 after tick", int'(ts_value), exp_slow * 20);
    idle(11);
    fire_event(1'b0);
    chk("R6", "ts phase 13", int'(ts_value), exp_slow * 20 + 13);
  endtask

  task automatic t_coarse();
    fast_en = 1'b0;
    idle(2);
    fire_event(1'b0);
    chk("R8", "coarse when off", int'(ts_coarse), 1);
    chk("R8", "no valid when off", int'(ts_valid), 0);
    chk("R8", "coarse value", int'(ts_value), exp_slow);
    pulse_tick();
    idle(3);
    fast_en = 1'b1;
    idle(3);
    pulse_tick();
    chk("R9", "interval kept", int'(interval_ticks), 20);
    fire_event(1'b0);
    chk("R8", "coarse before capture", int'(ts_coarse), 1);
    pulse_tick();
    idle(4);
    pulse_tick();
    chk("R4", "interval 5", int'(interval_ticks), 5);
    idle(2);
    fire_event(1'b0);
    chk("R6", "fine after recapture", int'(ts_value), exp_slow * 5 + 2);
  endtask

  task automatic t_saturate();
    pulse_tick();
    idle(300);
    fire_event(1'b0);
    chk("R3", "saturated phase", int'(ts_value), exp_slow * 5 + 255);
    pulse_tick();
    chk("R9", "interval after saturation", int'(interval_ticks), 5);
    fire_event(1'b0);
    chk("R9", "coarse after saturation", int'(ts_coarse), 1);
  endtask

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_wrap();
    t_sync();
    t_coincident();
    t_ratio2();
    t_coarse();
    t_saturate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule